// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is the serial register chain that sits between a chip's core and its pads for board-level test. It is built from four kinds of cell: input cells, output cells, output-enable cells, and read-only input cells. Every cell has a shift stage that joins the serial path from `scan_in` to `scan_out`. Input, output and enable cells also have an update stage that can take over the functional path. Read-only input cells leave their functional path untouched, so clocks and other inputs that are sensitive to timing carry no extra mux.

The test-access controller drives the chain through three strobes, a chain-select and a mode bit. The strobes are capture, shift and update, and each is one TCK wide. With mode low, pads and core see plain functional pass-through while the chain samples pin values and preloads data. This is the sample/preload behaviour. With mode high, output pads, their tri-state enables and the core-facing inputs are driven from the update stages. This is the external-test behaviour. Each enable cell controls a group of `OUT_PER_OE` adjacent outputs.

The strobes are sampled on the rising edge of `tck`. Reset is synchronous and active low.

Top module: `bscan_chain`

## Requirements
- R1: While `rst_n` is low at a rising edge of `tck`, every shift stage and every update stage is cleared to 0, so after that edge `scan_out` is 0.
- R2: When `chain_sel` and `capture_dr` are both high at an edge, each shift stage loads the value at its pad-side boundary. Input cells and read-only cells load their `pad_in`/`pad_ro` bit. Output cells load their current `pad_out` bit. Enable cells load the current pad-facing enable of their group. Capture takes precedence over shift.
- R3: When `chain_sel` and `shift_dr` are high and `capture_dr` is low, the chain moves one position toward `scan_out`, and `scan_in` enters the first cell. The serial order from `scan_in` is: input cells 0 upward, then read-only cells, then enable cells, then output cells. `scan_out` is the last output cell's shift stage.
- R4: When `chain_sel` and `update_dr` are high at an edge, every non-read-only cell copies its shift stage into its update stage. At any other edge the update stage holds, including during capture and shift.
- R5: With `test_mode` = 0: `pad_out` equals `core_out`, `pad_oe[j]` equals `core_oe[j / OUT_PER_OE]`, and `core_in` equals `pad_in`. All three paths are combinational.
- R6: With `test_mode` = 1: `pad_out[j]` is output cell j's update stage, and `pad_oe[j]` is the update stage of enable cell `j / OUT_PER_OE`. `core_in[i]` is input cell i's update stage.
- R7: `core_ro` equals `pad_ro` in both modes, and the shift stages of the read-only cells still capture and shift.
- R8: With `chain_sel` low, the strobes have no effect: shift and update stages hold, so `scan_out` and the mode-1 outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chain_sel | input | 1 | The current instruction selects this chain |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| test_mode | input | 1 | 0 = pass-through, 1 = drive from update stages |
| scan_in | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out |
| pad_in | input | N_IN | Input pads |
| core_in | output | N_IN | Input values toward the core |
| pad_ro | input | N_RO | Sensitive input pads |
| core_ro | output | N_RO | Sensitive inputs toward the core |
| core_out | input | N_OUT | Core output data |
| core_oe | input | N_OUT/OUT_PER_OE | Core tri-state enables, one per group |
| pad_out | output | N_OUT | Output pad data |
| pad_oe | output | N_OUT | Output pad enables |

## Verification
The functional-path results of R5, R6 and R7 follow the mode and the update stages with no register between them. The bench therefore compares them in the same cycle as the stimulus, half a period after the inputs settle. The effects of capture, shift, update and reset (R1 to R4, R8) show one edge after the strobe: `scan_out` shows the new last shift stage, and in mode 1 the pads show the new update stages. A behavioural model advances its queue at each rising edge and is compared at the following falling edge. Directed scans cover pass-through, preload, external test, an unselected chain and the capture-over-shift case. These are followed by long random strobe traffic.

// File: rtl/bscan_pkg.sv
// Package for the boundary-scan chain: cell kinds and chain layout helpers.
package bscan_pkg;

    // Kind of boundary cell; selects capture source and update stage.
    typedef enum logic [1:0] {
        CELL_IN  = 2'd0,
        CELL_RO  = 2'd1,
        CELL_OE  = 2'd2,
        CELL_OUT = 2'd3
    } cell_kind_e;

    // True when a cell of this kind owns an update stage.
    function automatic bit kind_has_update(cell_kind_e k);
        return k != CELL_RO;
    endfunction

    // True when a cell of this kind captures its pad-facing output.
    function automatic bit kind_captures_output(cell_kind_e k);
        return (k == CELL_OE) || (k == CELL_OUT);
    endfunction

endpackage

// File: rtl/bscan_cell.sv
// One boundary cell: a capture/shift stage plus, for every kind but the
// read-only input, an update stage and a mode mux on the functional path.
// Assumes strobes are already qualified with the chain select.
module bscan_cell
    import bscan_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_IN
) (
    input  logic tck,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shf_en,
    input  logic upd_en,
    input  logic mode,
    input  logic func_in,
    input  logic ser_in,
    output logic ser_q,
    output logic func_out
);
    localparam bit HasUpd = kind_has_update(KIND);
    localparam bit CapOut = kind_captures_output(KIND);

    logic cap_src;

    // Capture source: the pad-facing side of the cell.
    assign cap_src = CapOut ? func_out : func_in;

    // Capture/shift stage: capture wins over shift, otherwise hold.
    always_ff @(posedge tck) begin
        if (!rst_n)      ser_q <= 1'b0;
        else if (cap_en) ser_q <= cap_src;
        else if (shf_en) ser_q <= ser_in;
    end

    generate
        if (HasUpd) begin : g_upd
            logic upd_q;

            // Update stage: loads only on the update strobe.
            always_ff @(posedge tck) begin
                if (!rst_n)      upd_q <= 1'b0;
                else if (upd_en) upd_q <= ser_q;
            end

            // Functional path mux: test value when mode is high.
            assign func_out = mode ? upd_q : func_in;
        end else begin : g_ro
            // Read-only cell: functional path is a bare wire.
            assign func_out = func_in;
        end
    endgenerate

endmodule

// File: rtl/bscan_chain.sv
// Boundary-scan register chain. The serial order runs from scan_in
// through input cells, read-only cells, enable cells, then output cells,
// and ends at scan_out. Each enable cell governs OUT_PER_OE adjacent outputs.
// Assumes N_OUT is a multiple of OUT_PER_OE and the strobes are one tck wide.
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int N_IN       = 4,
    parameter int N_RO       = 2,
    parameter int N_OUT      = 4,
    parameter int OUT_PER_OE = 2,
    localparam int N_OE      = N_OUT / OUT_PER_OE
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             chain_sel,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             test_mode,
    input  logic             scan_in,
    output logic             scan_out,
    input  logic [N_IN-1:0]  pad_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_RO-1:0]  pad_ro,
    output logic [N_RO-1:0]  core_ro,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OE-1:0]  core_oe,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OUT-1:0] pad_oe
);
    localparam int RoBase  = N_IN;
    localparam int OeBase  = N_IN + N_RO;
    localparam int OutBase = N_IN + N_RO + N_OE;
    localparam int Len     = OutBase + N_OUT;

    logic         cap_en, shf_en, upd_en;
    logic [Len:0] ser;
    logic [N_OE-1:0] oe_grp;

    // Strobe qualification by the chain select.
    assign cap_en = chain_sel & capture_dr;
    assign shf_en = chain_sel & shift_dr;
    assign upd_en = chain_sel & update_dr;

    assign ser[0]   = scan_in;
    assign scan_out = ser[Len];

    genvar g;
    generate
        for (g = 0; g < N_IN; g++) begin : g_in
            bscan_cell #(.KIND(CELL_IN)) u_cell (
                .tck(tck), .rst_n(rst_n), .cap_en(cap_en), .shf_en(shf_en),
                .upd_en(upd_en), .mode(test_mode), .func_in(pad_in[g]),
                .ser_in(ser[g]), .ser_q(ser[g+1]), .func_out(core_in[g]));
        end
        for (g = 0; g < N_RO; g++) begin : g_ro
            bscan_cell #(.KIND(CELL_RO)) u_cell (
                .tck(tck), .rst_n(rst_n), .cap_en(cap_en), .shf_en(shf_en),
                .upd_en(upd_en), .mode(test_mode), .func_in(pad_ro[g]),
                .ser_in(ser[RoBase+g]), .ser_q(ser[RoBase+g+1]),
                .func_out(core_ro[g]));
        end
        for (g = 0; g < N_OE; g++) begin : g_oe
            bscan_cell #(.KIND(CELL_OE)) u_cell (
                .tck(tck), .rst_n(rst_n), .cap_en(cap_en), .shf_en(shf_en),
                .upd_en(upd_en), .mode(test_mode), .func_in(core_oe[g]),
                .ser_in(ser[OeBase+g]), .ser_q(ser[OeBase+g+1]),
                .func_out(oe_grp[g]));
        end
        for (g = 0; g < N_OUT; g++) begin : g_out
            bscan_cell #(.KIND(CELL_OUT)) u_cell (
                .tck(tck), .rst_n(rst_n), .cap_en(cap_en), .shf_en(shf_en),
                .upd_en(upd_en), .mode(test_mode), .func_in(core_out[g]),
                .ser_in(ser[OutBase+g]), .ser_q(ser[OutBase+g+1]),
                .func_out(pad_out[g]));
            // Enable fan-out: each pad takes its group's enable.
            assign pad_oe[g] = oe_grp[g / OUT_PER_OE];
        end
    endgenerate

endmodule

// File: rtl/bscan_chain_chk.sv
// Checker for bscan_chain: observes ports only and is attached with bind.
module bscan_chain_chk #(
    parameter int N_IN       = 4,
    parameter int N_RO       = 2,
    parameter int N_OUT      = 4,
    parameter int OUT_PER_OE = 2,
    localparam int N_OE      = N_OUT / OUT_PER_OE
) (
    input logic             tck,
    input logic             rst_n,
    input logic             chain_sel,
    input logic             capture_dr,
    input logic             shift_dr,
    input logic             update_dr,
    input logic             test_mode,
    input logic             scan_out,
    input logic [N_IN-1:0]  pad_in,
    input logic [N_IN-1:0]  core_in,
    input logic [N_RO-1:0]  pad_ro,
    input logic [N_RO-1:0]  core_ro,
    input logic [N_OUT-1:0] core_out,
    input logic [N_OE-1:0]  core_oe,
    input logic [N_OUT-1:0] pad_out,
    input logic [N_OUT-1:0] pad_oe
);
    logic [N_OUT-1:0] oe_exp;

    // Expanded core enables, one bit per output pad.
    always_comb begin
        for (int j = 0; j < N_OUT; j++) oe_exp[j] = core_oe[j / OUT_PER_OE];
    end

    // R5
    pass_through_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !test_mode |-> (pad_out == core_out) && (pad_oe == oe_exp) && (core_in == pad_in));

    // R7
    ro_wire_chk: assert property (@(posedge tck) disable iff (!rst_n)
        core_ro == pad_ro);

    // R8
    idle_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !chain_sel |=> $stable(scan_out));

    // R4
    upd_hold_out_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (test_mode && !(chain_sel && update_dr)) ##1 test_mode |-> $stable(pad_out) && $stable(pad_oe));

    // R4
    upd_hold_in_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (test_mode && !(chain_sel && update_dr)) ##1 test_mode |-> $stable(core_in));

endmodule

bind bscan_chain bscan_chain_chk #(
    .N_IN(N_IN), .N_RO(N_RO), .N_OUT(N_OUT), .OUT_PER_OE(OUT_PER_OE)
) u_chk (
    .tck(tck), .rst_n(rst_n), .chain_sel(chain_sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .test_mode(test_mode),
    .scan_out(scan_out), .pad_in(pad_in), .core_in(core_in), .pad_ro(pad_ro),
    .core_ro(core_ro), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/tb_bscan_chain.sv
// Bench for bscan_chain: a queue-based model stepped on each rising edge,
// with every output compared on each falling edge.
module tb_bscan_chain;
    localparam int N_IN = 4, N_RO = 2, N_OUT = 4, OPG = 2;
    localparam int N_OE = N_OUT / OPG;
    localparam int L = N_IN + N_RO + N_OE + N_OUT;

    logic tck = 1'b0, rst_n = 1'b0;
    logic chain_sel = 0, capture_dr = 0, shift_dr = 0, update_dr = 0, test_mode = 0;
    logic scan_in = 0, scan_out;
    logic [N_IN-1:0]  pad_in = '0, core_in;
    logic [N_RO-1:0]  pad_ro = '0, core_ro;
    logic [N_OUT-1:0] core_out = '0, pad_out, pad_oe;
    logic [N_OE-1:0]  core_oe = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    bscan_chain #(.N_IN(N_IN), .N_RO(N_RO), .N_OUT(N_OUT), .OUT_PER_OE(OPG)) dut (
        .tck(tck), .rst_n(rst_n), .chain_sel(chain_sel), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .test_mode(test_mode),
        .scan_in(scan_in), .scan_out(scan_out), .pad_in(pad_in), .core_in(core_in),
        .pad_ro(pad_ro), .core_ro(core_ro), .core_out(core_out), .core_oe(core_oe),
        .pad_out(pad_out), .pad_oe(pad_oe));

    always #5 tck = ~tck;

    // Model: queue index 0 is nearest scan_in; held[] are the update stages.
    logic q[$];
    logic held[L];

    function automatic logic m_core_in(int i);
        return test_mode ? held[i] : pad_in[i];
    endfunction
    function automatic logic m_oe(int j);
        return test_mode ? held[N_IN + N_RO + j / OPG] : core_oe[j / OPG];
    endfunction
    function automatic logic m_out(int j);
        return test_mode ? held[N_IN + N_RO + N_OE + j] : core_out[j];
    endfunction

    initial begin
        for (int k = 0; k < L; k++) begin q.push_back(1'b0); held[k] = 1'b0; end
    end

    always @(posedge tck) begin
        if (!rst_n) begin
            for (int k = 0; k < L; k++) begin q[k] = 1'b0; held[k] = 1'b0; end
        end else if (chain_sel) begin
            logic snap[L];
            for (int k = 0; k < L; k++) snap[k] = q[k];
            if (capture_dr) begin
                for (int i = 0; i < N_IN; i++) q[i] = pad_in[i];
                for (int r = 0; r < N_RO; r++) q[N_IN + r] = pad_ro[r];
                for (int e = 0; e < N_OE; e++) q[N_IN + N_RO + e] = m_oe(e * OPG);
                for (int o = 0; o < N_OUT; o++) q[N_IN + N_RO + N_OE + o] = m_out(o);
            end else if (shift_dr) begin
                q.push_front(scan_in);
                void'(q.pop_back());
            end
            if (update_dr)
                for (int k = 0; k < L; k++)
                    if (k < N_IN || k >= N_IN + N_RO) held[k] = snap[k];
        end
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison on the falling edge.
    always @(negedge tck) begin
        if (!done) begin
            logic [N_IN-1:0]  ei;
            logic [N_OUT-1:0] eo, ee;
            for (int i = 0; i < N_IN; i++) ei[i] = m_core_in(i);
            for (int j = 0; j < N_OUT; j++) begin eo[j] = m_out(j); ee[j] = m_oe(j); end
            check("R1/R2/R3/R8 scan_out", 16'(scan_out), 16'(q[L-1]));
            check("R5/R6 core_in", 16'(core_in), 16'(ei));
            check("R4/R5/R6 pad_out", 16'(pad_out), 16'(eo));
            check("R5/R6 pad_oe", 16'(pad_oe), 16'(ee));
            check("R7 core_ro", 16'(core_ro), 16'(pad_ro));
        end
    end

    task automatic step(logic sel, logic cap, logic sh, logic up, logic si);
        @(posedge tck); #1;
        chain_sel = sel; capture_dr = cap; shift_dr = sh; update_dr = up; scan_in = si;
    endtask

    task automatic scan_bits(logic [31:0] pat);
        for (int k = 0; k < L; k++) step(1, 0, 1, 0, pat[k]);
    endtask

    initial begin
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        @(posedge tck); #1 rst_n = 1;
        // R1 reset state then R5 pass-through with patterns
        pad_in = 4'b1010; core_out = 4'b0110; core_oe = 2'b01; pad_ro = 2'b10;
        step(0, 0, 0, 0, 0);
        // R2 capture in mode 0, then R3 shift out and R4 preload
        step(1, 1, 0, 0, 0);
        scan_bits(32'h0000_0A5C);
        step(1, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0);
        // R6 external test from preloaded values
        test_mode = 1;
        step(0, 0, 0, 0, 0);
        core_out = 4'b1001; pad_in = 4'b0101;
        step(1, 1, 0, 0, 0);
        scan_bits(32'h0000_03F1);
        step(1, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0);
        // R8 unselected strobes ignored
        step(0, 1, 0, 0, 1);
        step(0, 0, 1, 0, 1);
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 0);
        // R2 capture beats shift when both strobes are high
        step(1, 1, 1, 0, 1);
        step(0, 0, 0, 0, 0);
        // R7 sensitive input changes in mode 1
        pad_ro = 2'b01;
        step(0, 0, 0, 0, 0);
        // Random traffic, including mid-run reset
        for (int n = 0; n < 3000; n++) begin
            pad_in = 4'($urandom); pad_ro = 2'($urandom);
            core_out = 4'($urandom); core_oe = 2'($urandom);
            if ((n % 97) == 0) test_mode = ~test_mode;
            if (n == 1500) rst_n = 0;
            if (n == 1502) rst_n = 1;
            step(($urandom % 8) != 0, ($urandom % 6) == 0, ($urandom % 2) == 0,
                 ($urandom % 5) == 0, 1'($urandom));
        end
        step(0, 0, 0, 0, 0);
        @(negedge tck);
        #1 done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule